// File: doc/BRIEF.md
# Voiced/Unvoiced Excitation Source

This block is the excitation stage of a source-filter speech synthesizer. On every sample strobe it produces one signed sample for the downstream filter engine. In a voiced segment the sample is a pulse train: one positive pulse at the start of each pitch period and zero for the rest of the period. In an unvoiced segment the sample is pseudo-random noise of fixed magnitude, with its sign taken from a 17-bit linear feedback shift register.

A controller drives three segment parameters: a pitch period in samples, a voiced flag and a duration counted in pitch periods. The block takes these parameters only at a period boundary that follows the end of the previous segment. It raises a one-clock done pulse when the final period of a segment begins. This gives the controller one full period to present the next segment before the block loads it.

Top module: `exc_source`

## Requirements
- R1: While `rst` is high, and after it falls until the first strobe, `sample` is 0 and `seg_done` is 0. The shift register returns to its seed of 1. The first strobe after reset begins a period and loads the configuration inputs.
- R2: `sample` and `seg_done` change only in the clock after a cycle in which `smp_stb` is high. Without a strobe, `sample` holds its value and `seg_done` is 0.
- R3: In a voiced segment (`cfg_voiced`=1 at load), the strobe that begins a period gives `sample` = PULSE_AMP (default 1000). Every other strobe gives 0. Periods are `pitch` strobes long.
- R4: A pitch value of 0 is treated as 1, so every strobe begins a period.
- R5: In an unvoiced segment, each strobe gives `sample` = -NOISE_AMP when the bit newly inserted into the shift register is 1, and +NOISE_AMP (default 256) when it is 0.
- R6: The shift register is 17 bits wide. On every strobe, in both modes, it shifts left by one and inserts bit16 XOR bit2 at bit 0. It never holds all zeros.
- R7: A segment lasts `dur` periods, with a duration of 0 treated as 1. `seg_done` is high for one clock after the strobe that begins the segment's last period.
- R8: The configuration is sampled only at a strobe that begins a period after the previous segment's duration has run out. Changes at any other time have no effect on `sample` or `seg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe; one output sample per strobe |
| cfg_pitch | input | PITCH_W (8) | Pitch period in samples (0 acts as 1) |
| cfg_voiced | input | 1 | 1 = pulse excitation, 0 = noise excitation |
| cfg_dur | input | DUR_W (8) | Segment length in pitch periods (0 acts as 1) |
| sample | output | SAMP_W (12) | Signed excitation sample, held between strobes |
| seg_done | output | 1 | One-clock pulse when the last period of a segment starts |

## Verification
The bench plays a sequence of segments that mixes voiced and unvoiced modes, pitch 0 and 1, and durations 0 and 1. It drives junk configuration values during each segment. A design that latched parameters early would pick up this junk and change its pulse spacing or mode partway through a segment. A pitch of 0 without the clamp would underflow the period counter and space pulses 256 strobes apart. A duration of 0 handled off by one would run 256 periods or never raise done. A noise mode that stopped the shift register while voiced, or that used the wrong tap, would give the wrong sign sequence after a voiced segment. A reset in the middle of the run checks that the noise restarts from the seed.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int LFSR_W  = 17;
    localparam int TAP_HI  = 16;
    localparam int TAP_LO  = 2;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic {
        EXC_NOISE = 1'b0,
        EXC_PULSE = 1'b1
    } exc_mode_e;

    function automatic logic lfsr_feedback(input lfsr_t s);
        return s[TAP_HI] ^ s[TAP_LO];
    endfunction

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], lfsr_feedback(s)};
    endfunction

endpackage

// File: rtl/exc_lfsr.sv
module exc_lfsr
    import exc_pkg::*;
#(
    parameter lfsr_t SEED = lfsr_t'(1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output logic  new_bit,
    output lfsr_t state
);
    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (adv)
            state_q <= lfsr_step(state_q);
    end

    assign new_bit = lfsr_feedback(state_q);
    assign state   = state_q;
endmodule

// File: rtl/exc_pitch.sv
module exc_pitch #(
    parameter int PITCH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [PITCH_W-1:0] period_len,
    output logic               period_start
);
    logic [PITCH_W-1:0] phase_q;

    assign period_start = (phase_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (adv) begin
            if (period_start)
                phase_q <= period_len - PITCH_W'(1);
            else
                phase_q <= phase_q - PITCH_W'(1);
        end
    end
endmodule

// File: rtl/exc_segment.sv
module exc_segment
    import exc_pkg::*;
#(
    parameter int PITCH_W = 8,
    parameter int DUR_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic               period_start,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic               cfg_voiced,
    input  logic [DUR_W-1:0]   cfg_dur,
    output logic [PITCH_W-1:0] act_pitch,
    output exc_mode_e          act_mode,
    output logic               done
);
    logic [PITCH_W-1:0] pitch_q;
    exc_mode_e          mode_q;
    logic [DUR_W-1:0]   left_q;
    logic               done_q;

    logic               load;
    logic               last;
    logic [PITCH_W-1:0] pitch_eff;
    logic [DUR_W-1:0]   left_init;

    assign load      = period_start && (left_q == '0);
    assign pitch_eff = (cfg_pitch == '0) ? PITCH_W'(1) : cfg_pitch;
    assign left_init = (cfg_dur == '0) ? '0 : cfg_dur - DUR_W'(1);
    assign last      = load ? (cfg_dur <= DUR_W'(1)) : (left_q == DUR_W'(1));

    assign act_pitch = load ? pitch_eff : pitch_q;
    assign act_mode  = load ? (cfg_voiced ? EXC_PULSE : EXC_NOISE) : mode_q;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pitch_q <= PITCH_W'(1);
            mode_q  <= EXC_NOISE;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= adv && period_start && last;
            if (adv && period_start) begin
                if (load) begin
                    pitch_q <= pitch_eff;
                    mode_q  <= cfg_voiced ? EXC_PULSE : EXC_NOISE;
                    left_q  <= left_init;
                end else begin
                    left_q  <= left_q - DUR_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/exc_source.sv
module exc_source
    import exc_pkg::*;
#(
    parameter int    PITCH_W   = 8,
    parameter int    DUR_W     = 8,
    parameter int    SAMP_W    = 12,
    parameter int    PULSE_AMP = 1000,
    parameter int    NOISE_AMP = 256,
    parameter lfsr_t LFSR_SEED = lfsr_t'(1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_stb,
    input  logic [PITCH_W-1:0]       cfg_pitch,
    input  logic                     cfg_voiced,
    input  logic [DUR_W-1:0]         cfg_dur,
    output logic signed [SAMP_W-1:0] sample,
    output logic                     seg_done
);
    localparam logic signed [SAMP_W-1:0] PULSE_S = SAMP_W'(PULSE_AMP);
    localparam logic signed [SAMP_W-1:0] NOISE_S = SAMP_W'(NOISE_AMP);

    logic               period_start;
    logic [PITCH_W-1:0] act_pitch;
    exc_mode_e          act_mode;
    logic               noise_bit;
    lfsr_t              lfsr_q;
    logic signed [SAMP_W-1:0] sample_q;

    exc_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .adv     (smp_stb),
        .new_bit (noise_bit),
        .state   (lfsr_q)
    );

    exc_pitch #(.PITCH_W(PITCH_W)) u_pitch (
        .clk          (clk),
        .rst          (rst),
        .adv          (smp_stb),
        .period_len   (act_pitch),
        .period_start (period_start)
    );

    exc_segment #(.PITCH_W(PITCH_W), .DUR_W(DUR_W)) u_seg (
        .clk          (clk),
        .rst          (rst),
        .adv          (smp_stb),
        .period_start (period_start),
        .cfg_pitch    (cfg_pitch),
        .cfg_voiced   (cfg_voiced),
        .cfg_dur      (cfg_dur),
        .act_pitch    (act_pitch),
        .act_mode     (act_mode),
        .done         (seg_done)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sample_q <= '0;
        else if (smp_stb) begin
            if (act_mode == EXC_PULSE)
                sample_q <= period_start ? PULSE_S : '0;
            else
                sample_q <= noise_bit ? -NOISE_S : NOISE_S;
        end
    end

    assign sample = sample_q;
endmodule

// File: rtl/exc_source_chk.sv
module exc_source_chk
    import exc_pkg::*;
#(
    parameter int SAMP_W    = 12,
    parameter int PULSE_AMP = 1000,
    parameter int NOISE_AMP = 256
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     smp_stb,
    input logic signed [SAMP_W-1:0] sample,
    input logic                     seg_done,
    input lfsr_t                    lfsr_state
);
    localparam logic signed [SAMP_W-1:0] P_S = SAMP_W'(PULSE_AMP);
    localparam logic signed [SAMP_W-1:0] N_S = SAMP_W'(NOISE_AMP);

    assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        seg_done |-> $past(smp_stb));

    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(sample));

    assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    assert_sample_levels_R5: assert property (@(posedge clk) disable iff (rst)
        (sample == '0) || (sample == P_S) || (sample == N_S) || (sample == -N_S));
endmodule

bind exc_source exc_source_chk #(
    .SAMP_W    (SAMP_W),
    .PULSE_AMP (PULSE_AMP),
    .NOISE_AMP (NOISE_AMP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .sample     (sample),
    .seg_done   (seg_done),
    .lfsr_state (lfsr_q)
);

// File: tb/test_exc_source.sv
`timescale 1ns/100ps
module test_exc_source;
    localparam int PULSE = 1000;
    localparam int NOISE = 256;
    localparam int NSEG  = 7;
    // {pitch, voiced, duration}
    localparam int VEC [NSEG][3] = '{
        '{4, 1, 3}, '{0, 1, 2}, '{5, 0, 2}, '{3, 1, 0},
        '{1, 0, 4}, '{7, 1, 1}, '{2, 0, 1}
    };

    logic clk = 0;
    logic rst = 1;
    logic stb = 0;
    logic [7:0] cfg_pitch = 0;
    logic cfg_voiced = 0;
    logic [7:0] cfg_dur = 0;
    logic signed [11:0] sample;
    logic seg_done;

    int checks = 0, fails = 0;
    bit finished = 0;

    int m_ph, m_dur, m_pitch;
    bit m_voiced;
    logic [16:0] m_lfsr;
    int exp_sample;
    bit exp_done, exp_load;

    always #2.5 clk = ~clk;

    exc_source i_exc_source (
        .clk(clk), .rst(rst), .smp_stb(stb),
        .cfg_pitch(cfg_pitch), .cfg_voiced(cfg_voiced), .cfg_dur(cfg_dur),
        .sample(sample), .seg_done(seg_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_dur = 0; m_pitch = 1; m_voiced = 0; m_lfsr = 17'h1;
    endtask

    task automatic model_step();
        bit nb, start, last;
        nb = m_lfsr[16] ^ m_lfsr[2];
        m_lfsr = {m_lfsr[15:0], nb};
        start = (m_ph == 0);
        last = 0;
        exp_load = 0;
        if (start) begin
            if (m_dur == 0) begin
                exp_load = 1;
                m_pitch = (cfg_pitch == 0) ? 1 : int'(cfg_pitch);
                m_voiced = cfg_voiced;
                last = (cfg_dur <= 1);
                m_dur = (cfg_dur == 0) ? 0 : int'(cfg_dur) - 1;
            end else begin
                last = (m_dur == 1);
                m_dur--;
            end
            m_ph = m_pitch - 1;
        end else
            m_ph--;
        exp_sample = m_voiced ? (start ? PULSE : 0) : (nb ? -NOISE : NOISE);
        exp_done = start && last;
    endtask

    task automatic strobe();
        @(negedge clk) stb = 1;
        model_step();
        @(negedge clk) stb = 0;
    endtask

    task automatic run_segment(input int p, input int v, input int d, input string tag);
        int held;
        bit junk = 0;
        cfg_pitch = 8'(p); cfg_voiced = v[0]; cfg_dur = 8'(d);
        for (int guard = 0; guard < 4000; guard++) begin
            strobe();
            check(junk ? "R8 sample" : tag, int'(sample), exp_sample);
            check("R7 done", int'(seg_done), int'(exp_done));
            held = int'(sample);
            @(negedge clk);
            check("R2 hold", int'(sample), held);
            check("R2 done low", int'(seg_done), 0);
            if (exp_load) begin
                junk = 1;
                cfg_pitch = 8'(p) ^ 8'h5A; cfg_voiced = ~v[0]; cfg_dur = 8'hFF;
            end
            if (exp_done) break;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        string tag;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 sample in reset", int'(sample), 0);
        check("R1 done in reset", int'(seg_done), 0);
        @(negedge clk) rst = 0;
        repeat (2) @(negedge clk);
        check("R1 sample after reset", int'(sample), 0);
        check("R1 done after reset", int'(seg_done), 0);

        for (int i = 0; i < NSEG; i++) begin
            if (VEC[i][0] == 0) tag = "R4 pitch zero";
            else if (VEC[i][1] == 1) tag = "R3 pulse";
            else tag = "R5 R6 noise";
            run_segment(VEC[i][0], VEC[i][1], VEC[i][2], tag);
        end

        // mid-run reset restarts the noise from the seed
        @(negedge clk) rst = 1;
        repeat (2) @(negedge clk);
        check("R1 sample reset mid-run", int'(sample), 0);
        check("R1 done reset mid-run", int'(seg_done), 0);
        rst = 0;
        model_reset();
        run_segment(2, 0, 3, "R6 noise after reset");
        run_segment(1, 1, 2, "R3 R4 pitch one");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule